// File: doc/BRIEF.md
# Sixteen-Mode Arithmetic and Logic Unit with Status Flags

This block is a purely combinational datapath unit for a small accumulator machine. Two 8-bit operands arrive on each evaluation. `acc_in` is the accumulator side and `arg_in` is the immediate or memory side. A 4-bit operation code picks one of sixteen functions:

- arithmetic
- bitwise logic
- operand moves
- increment and decrement
- rotates
- logical and arithmetic shifts
- two's complement negation

The unit drives an 8-bit result and a 4-bit status word. A surrounding core latches the status word into its status register.

The lower eight codes line up with the accumulator-with-immediate instruction group, so a decoder can forward those opcode bits unchanged. Increment and decrement act on `arg_in`. Rotates, shifts and negation act on `acc_in`. A core uses the block by presenting operands and code in one cycle and capturing `res_out` and `stat_out` at its next clock edge. The block has no state, so there is no reset, clock or handshake.

The status word `stat_out` is packed as follows:

| Bit | Name | Meaning |
|-----|------|---------|
| 3 | Z | Zero |
| 2 | C | Carry or borrow |
| 1 | S | Sign |
| 0 | O | Signed overflow |

Top module: `mode16_alu`

## Requirements
- R1: Code 0000 (add) gives `res_out` = (acc + arg) mod 256. C is the carry out of bit 7. O is set when the signed sum lies outside -128..127.
- R2: Code 0001 (subtract) gives (acc - arg) mod 256. C is set when acc < arg, taken unsigned (a borrow). O is set when the signed difference lies outside -128..127.
- R3: Code 0111 (reverse subtract) gives (arg - acc) mod 256. C is set when arg < acc, taken unsigned. O is set when the signed difference lies outside -128..127.
- R4: Codes 0010 (copy acc), 0011 (copy arg), 0100 (AND), 0101 (OR) and 0110 (XOR) give the named value, and both C and O are 0.
- R5: Code 1000 gives arg + 1 and code 1001 gives arg - 1, both mod 256, whatever the value of acc. For code 1000, C is set when arg = 0xFF and O is set when arg = 0x7F. For code 1001, C is set when arg = 0x00 and O is set when arg = 0x80.
- R6: Code 1010 rotates acc left by one, and C takes the old bit 7. Code 1011 rotates acc right by one, and C takes the old bit 0. arg has no effect and O is 0.
- R7: Code 1100 shifts acc left, fills with zero, and C takes the old bit 7. Code 1101 shifts acc right, fills with zero, and C takes the old bit 0. Code 1110 shifts acc right, keeps bit 7, and C takes the old bit 0. arg has no effect and O is 0.
- R8: Code 1111 gives (0 - acc) mod 256. C is set when acc is nonzero and O is set when acc = 0x80. arg has no effect.
- R9: In every mode, Z (`stat_out[3]`) is 1 exactly when `res_out` is 0 and S (`stat_out[1]`) equals `res_out[7]`. C sits at bit 2 and O at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 8 | First operand (accumulator side) |
| arg_in | input | 8 | Second operand (immediate or data side) |
| op_in | input | 4 | Operation code |
| res_out | output | 8 | Operation result |
| stat_out | output | 4 | Status word {Z, C, S, O} |

## Verification
The hardest cases to reach are the signed-overflow and borrow edges. These include increment of 0x7F, decrement of 0x00 and 0x80, negation of 0x80, and sums that cross from 0x7F to 0x80. Each of them holds for only a handful of operand pairs among 65,536. The bench sweeps every value of `acc_in` against a spread of `arg_in` values that is forced to contain 0x00, 0x01, 0x7F, 0x80 and 0xFF. In the modes that use a single operand, it sweeps that operand in full while changing the ignored one, so every corner appears and any leak from the unused operand shows at the outputs.

// File: rtl/mode16_alu_pkg.sv
package mode16_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_CPA  = 4'b0010,
    OP_CPB  = 4'b0011,
    OP_AND  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_RSUB = 4'b0111,
    OP_INC  = 4'b1000,
    OP_DEC  = 4'b1001,
    OP_ROL  = 4'b1010,
    OP_ROR  = 4'b1011,
    OP_SHL  = 4'b1100,
    OP_SHR  = 4'b1101,
    OP_ASR  = 4'b1110,
    OP_NEG  = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH,
    CLS_BITW,
    CLS_SHIFT
  } op_class_e;

  // positions inside the status word
  localparam int STAT_Z = 3;
  localparam int STAT_C = 2;
  localparam int STAT_S = 1;
  localparam int STAT_O = 0;
  localparam int STAT_W = 4;

  function automatic op_class_e class_of(input alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_RSUB, OP_INC, OP_DEC, OP_NEG: class_of = CLS_ARITH;
      OP_ROL, OP_ROR, OP_SHL, OP_SHR, OP_ASR:          class_of = CLS_SHIFT;
      default:                                         class_of = CLS_BITW;
    endcase
  endfunction

endpackage

// File: rtl/m16_addsub.sv
module m16_addsub
  import mode16_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  alu_op_e       op,
  output logic [DW-1:0] sum,
  output logic          carry,
  output logic          ovf
);
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] xin;
  logic [DW-1:0] yin;
  logic          cin;
  logic          inv_c;
  logic [DW:0]   total;

  // steer both operands into one adder; subtractions use inverted input + 1
  always_comb begin
    xin   = opa;
    yin   = opb;
    cin   = 1'b0;
    inv_c = 1'b0;
    case (op)
      OP_SUB:  begin yin = ~opb;              cin = 1'b1; inv_c = 1'b1; end
      OP_RSUB: begin xin = opb;  yin = ~opa;  cin = 1'b1; inv_c = 1'b1; end
      OP_INC:  begin xin = opb;  yin = '0;    cin = 1'b1;               end
      OP_DEC:  begin xin = opb;  yin = '1;                 inv_c = 1'b1; end
      OP_NEG:  begin xin = '0;   yin = ~opa;  cin = 1'b1; inv_c = 1'b1; end
      default: ;
    endcase
  end

  assign total = {1'b0, xin} + {1'b0, yin} + {{DW{1'b0}}, cin};
  assign sum   = total[DW-1:0];
  // a missing carry out of an inverted-operand add is a borrow
  assign carry = total[DW] ^ inv_c;
  assign ovf   = (xin[MSB] == yin[MSB]) && (sum[MSB] != xin[MSB]);

  logic [DW:0]   ref_add;
  logic [DW-1:0] ref_rsub;
  assign ref_add  = {1'b0, opa} + {1'b0, opb};
  assign ref_rsub = opb - opa;

  always_comb begin
    // R1
    add_carry_chk: assert (op != OP_ADD || {carry, sum} == ref_add)
      else $error("add carry/sum mismatch");
    // R2
    sub_borrow_chk: assert (op != OP_SUB || carry == (opa < opb))
      else $error("subtract borrow mismatch");
    // R3
    rsub_value_chk: assert (op != OP_RSUB || sum == ref_rsub)
      else $error("reverse subtract value mismatch");
    // R5
    inc_overflow_chk: assert (op != OP_INC || ovf == (opb == MAX_POS))
      else $error("increment overflow mismatch");
  end

endmodule

// File: rtl/m16_bitwise.sv
module m16_bitwise
  import mode16_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  alu_op_e       op,
  output logic [DW-1:0] res
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      case (op)
        OP_CPB:  res[i] = opb[i];
        OP_AND:  res[i] = opa[i] & opb[i];
        OP_OR:   res[i] = opa[i] | opb[i];
        OP_XOR:  res[i] = opa[i] ^ opb[i];
        default: res[i] = opa[i];
      endcase
    end
  end

endmodule

// File: rtl/m16_shifter.sv
module m16_shifter
  import mode16_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opa,
  input  alu_op_e       op,
  output logic [DW-1:0] res,
  output logic          out_bit
);
  localparam int MSB = DW - 1;

  always_comb begin
    res     = opa;
    out_bit = 1'b0;
    case (op)
      OP_ROL: begin res = {opa[MSB-1:0], opa[MSB]}; out_bit = opa[MSB]; end
      OP_ROR: begin res = {opa[0], opa[MSB:1]};     out_bit = opa[0];   end
      OP_SHL: begin res = {opa[MSB-1:0], 1'b0};     out_bit = opa[MSB]; end
      OP_SHR: begin res = {1'b0, opa[MSB:1]};       out_bit = opa[0];   end
      OP_ASR: begin res = {opa[MSB], opa[MSB:1]};   out_bit = opa[0];   end
      default: ;
    endcase
  end

endmodule

// File: rtl/mode16_alu.sv
module mode16_alu
  import mode16_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     arg_in,
  input  logic [3:0]        op_in,
  output logic [DW-1:0]     res_out,
  output logic [STAT_W-1:0] stat_out
);
  localparam int MSB = DW - 1;

  alu_op_e   op;
  op_class_e cls;
  assign op  = alu_op_e'(op_in);
  assign cls = class_of(op);

  logic [DW-1:0] ar_res, bw_res, sh_res;
  logic          ar_c, ar_o, sh_c;

  m16_addsub #(.DW(DW)) u_addsub (
    .opa(acc_in), .opb(arg_in), .op(op),
    .sum(ar_res), .carry(ar_c), .ovf(ar_o)
  );

  m16_bitwise #(.DW(DW)) u_bitwise (
    .opa(acc_in), .opb(arg_in), .op(op), .res(bw_res)
  );

  m16_shifter #(.DW(DW)) u_shifter (
    .opa(acc_in), .op(op), .res(sh_res), .out_bit(sh_c)
  );

  logic c_sel, o_sel;

  always_comb begin
    case (cls)
      CLS_ARITH: begin res_out = ar_res; c_sel = ar_c; o_sel = ar_o; end
      CLS_SHIFT: begin res_out = sh_res; c_sel = sh_c; o_sel = 1'b0; end
      default:   begin res_out = bw_res; c_sel = 1'b0; o_sel = 1'b0; end
    endcase
  end

  always_comb begin
    stat_out         = '0;
    stat_out[STAT_Z] = ~|res_out;
    stat_out[STAT_C] = c_sel;
    stat_out[STAT_S] = res_out[MSB];
    stat_out[STAT_O] = o_sel;
  end

  logic [DW-1:0] neg_check;
  assign neg_check = res_out + acc_in;

  always_comb begin
    // R4
    bitw_flags_chk: assert (cls != CLS_BITW ||
                            (!stat_out[STAT_C] && !stat_out[STAT_O]))
      else $error("logic/move mode raised C or O");
    // R6
    rotate_out_chk: assert (!(op == OP_ROL && stat_out[STAT_C] != acc_in[MSB]) &&
                            !(op == OP_ROR && stat_out[STAT_C] != acc_in[0]))
      else $error("rotate carry is not the bit moved out");
    // R7
    shift_clean_chk: assert (!(op == OP_SHL || op == OP_SHR || op == OP_ASR) ||
                             !stat_out[STAT_O])
      else $error("shift mode raised O");
    // R8
    neg_sum_chk: assert (op != OP_NEG || neg_check == '0)
      else $error("negation does not cancel operand");
    // R9
    zero_sign_chk: assert (!(stat_out[STAT_Z] && stat_out[STAT_S]))
      else $error("zero and sign set together");
  end

endmodule

// File: tb/mode16_alu_bench.sv
module mode16_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic [7:0] acc_in = '0;
  logic [7:0] arg_in = '0;
  logic [3:0] op_in = '0;
  logic [7:0] res_out;
  logic [3:0] stat_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mode16_alu u_mode16_alu (
    .acc_in(acc_in), .arg_in(arg_in), .op_in(op_in),
    .res_out(res_out), .stat_out(stat_out)
  );

  function automatic string req_of(input int m);
    case (m)
      0:             return "R1";
      1:             return "R2";
      7:             return "R3";
      8, 9:          return "R5";
      10, 11:        return "R6";
      12, 13, 14:    return "R7";
      15:            return "R8";
      default:       return "R4";
    endcase
  endfunction

  // returns {Z, C, S, O, result}
  function automatic logic [11:0] model(input int m, input int a, input int b);
    int sa, sb, r, sr;
    bit c, o;
    logic [7:0] res;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    c = 0; o = 0; r = 0; sr = 0;
    case (m)
      0:  begin r = a + b; c = (r > 255); sr = sa + sb; o = (sr > 127 || sr < -128); end
      1:  begin r = a - b; c = (r < 0);   sr = sa - sb; o = (sr > 127 || sr < -128); end
      2:  r = a;
      3:  r = b;
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7:  begin r = b - a; c = (r < 0);   sr = sb - sa; o = (sr > 127 || sr < -128); end
      8:  begin r = b + 1; c = (r > 255); sr = sb + 1;  o = (sr > 127); end
      9:  begin r = b - 1; c = (r < 0);   sr = sb - 1;  o = (sr < -128); end
      10: begin r = (a * 2) % 256 + a / 128; c = (a >= 128); end
      11: begin r = a / 2 + (a % 2) * 128;   c = (a % 2 == 1); end
      12: begin r = (a * 2) % 256;           c = (a >= 128); end
      13: begin r = a / 2;                   c = (a % 2 == 1); end
      14: begin r = a / 2 + (a / 128) * 128; c = (a % 2 == 1); end
      default: begin r = -a; c = (a != 0); sr = -sa; o = (sr > 127); end
    endcase
    res = 8'(r & 255);
    return {res == 8'd0, c, res[7], o, res};
  endfunction

  task automatic run_vec(input int m, input int a, input int b);
    logic [11:0] exp;
    op_in  = 4'(m);
    acc_in = 8'(a);
    arg_in = 8'(b);
    #1;
    exp = model(m, a, b);
    checks++;
    if (res_out != exp[7:0] || stat_out[2] != exp[10] || stat_out[0] != exp[8]) begin
      errors++;
      $display("FAIL %s mode=%0d a=%02h b=%02h: res/C/O actual %02h/%b/%b expected %02h/%b/%b",
               req_of(m), m, a, b, res_out, stat_out[2], stat_out[0],
               exp[7:0], exp[10], exp[8]);
    end
    checks++;
    // R9: Z at bit 3, S at bit 1
    if (stat_out[3] != exp[11] || stat_out[1] != exp[9]) begin
      errors++;
      $display("FAIL R9 mode=%0d a=%02h b=%02h: Z/S actual %b/%b expected %b/%b",
               m, a, b, stat_out[3], stat_out[1], exp[11], exp[9]);
    end
  endtask

  initial begin
    #2;
    // all-zero inputs: add of zeros gives zero with only Z set (R1, R9)
    run_vec(0, 0, 0);
    // two-operand modes (R1, R2, R3, R4): every acc value against a spread of arg values
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 7) run_vec(m, a, b);
        run_vec(m, a, 8'h01);
        run_vec(m, a, 8'h7F);
        run_vec(m, a, 8'h80);
        run_vec(m, a, 8'hFF);
      end
    end
    // single-operand modes (R5, R6, R7, R8): full sweep, ignored operand varied
    for (int m = 8; m < 16; m++) begin
      for (int v = 0; v < 256; v++) begin
        if (m < 10) begin
          run_vec(m, 8'h00, v);
          run_vec(m, 8'h5A, v);
          run_vec(m, 8'hFF, v);
        end else begin
          run_vec(m, v, 8'h00);
          run_vec(m, v, 8'hA5);
          run_vec(m, v, 8'hFF);
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule